// File: doc/BRIEF.md
# SPI Controller Register and Event Front-End

This block is the bus-facing half of a SPI master. It decodes 32-bit register accesses and holds the following state:

- a controller mode word;
- an event register and a mask register;
- a command word;
- four per-select mode words.

It also owns two 32-byte FIFOs that sit between software and the serial engine. The engine itself is outside the block. It sees two things from this block:

- byte-wide valid/ready handshakes on both FIFOs;
- the command word, a one-cycle start pulse and the stored mode words.

Software writes transmit data as whole words or as single bytes. It reads received data the same two ways. Byte reads drain a trailing partial word one byte at a time. The event register shows the live byte count of each FIFO. It also holds two sticky flags, receive-not-empty and transmit-not-full, which software clears by writing ones. The interrupt output is the OR of the sticky flags ANDed with their mask bits.

Top module: `spi_regfront`

## Requirements
- R1: While reset is held and after it releases, the mode, mask, command and per-select words read 0, `irq`, `cmd_start` and `xfer_busy` are 0, `eng_tx_valid` is 0 and `eng_rx_ready` is 1. One clock after reset the event register reads 0x00000100.
- R2: The mode word (byte address 0x00), mask (0x08) and per-select words (0x20, 0x24, 0x28, 0x2C) read back what was written. Their values also appear on `mode_word` and on `sel_mode_flat`, where select s occupies bits [32s+31:32s].
- R3: Reads of 0x18 and 0x1C return 0, and writes to them change no other register.
- R4: A word write to 0x10 queues four transmit bytes, bits [31:24] first. A byte write (`bus_byte`=1) queues bits [7:0]. A word write that finds fewer than 4 free bytes is dropped whole.
- R5: A word read of 0x14 returns the oldest received byte in bits [31:24], followed by the next bytes in the lower lanes. It removes up to four bytes, and lanes with no byte read 0. A byte read returns the oldest byte in bits [7:0] and removes it. A read of an empty FIFO returns 0.
- R6: Event bits [29:24] give the live receive FIFO byte count and bits [21:16] the live transmit count.
- R7: Event bit 9 (receive not empty) and bit 8 (transmit not full) become 1 one clock after their condition holds. They stay 1 until a write of 1 to that bit at 0x04. In the clock of that write the clear wins. If the condition still holds, the bit returns one clock later.
- R8: `irq` is 1 exactly when event bit 9 or 8 is set together with the same bit of the mask at 0x08.
- R9: A write to 0x0C while idle stores the word, which reads back at 0x0C and drives `cmd_word`. It raises `cmd_start` for one clock and sets `xfer_busy` until `eng_done`. Writes while busy are ignored.
- R10: `eng_tx_valid` is 1 while the transmit FIFO holds a byte, with the oldest byte on `eng_tx_data`. `eng_rx_ready` is 0 while the receive FIFO holds 32 bytes, and a byte offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | Byte-sized access to the data ports |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Masked event interrupt |
| mode_word | output | 32 | Controller mode word |
| sel_mode_flat | output | 128 | Four per-select mode words |
| cmd_word | output | 32 | Accepted command word |
| cmd_start | output | 1 | One-clock transaction start pulse |
| xfer_busy | output | 1 | Transaction in progress |
| eng_done | input | 1 | Engine reports transaction end |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_tx_ready | input | 1 | Engine takes transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_valid | input | 1 | Engine offers received byte |
| eng_rx_ready | output | 1 | Receive FIFO has room |
| eng_rx_data | input | 8 | Received byte |

## Verification
A FIFO pointer or count that goes wrong shows up quickly at the ports:

- the event count fields read wrong on the next register read;
- bytes leave the FIFO out of order on `eng_tx_data`, or in the wrong lanes of a receive word read, on the next pop.

A wrong sticky flag shows up in two places:

- the read in the clock right after a clear returns the bit when it should not;
- the bit drops early once a FIFO drains.

Either way `irq` follows within the same clock. A busy flag that fails to hold shows up in the very next clock: an ignored command write changes `cmd_word` or produces a second start pulse.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 32;
  localparam int LANES       = 4;
  localparam int CNT_FIELD_W = 6;

  // byte addresses of the register slots
  localparam int OFS_MODE  = 'h00;
  localparam int OFS_EVENT = 'h04;
  localparam int OFS_MASK  = 'h08;
  localparam int OFS_CMD   = 'h0C;
  localparam int OFS_TXD   = 'h10;
  localparam int OFS_RXD   = 'h14;
  localparam int OFS_SEL   = 'h20;

  // event bit positions, shared by the mask register
  localparam int BIT_RX_NE = 9;
  localparam int BIT_TX_NF = 8;

  // assemble the event word from live counts and sticky flags
  function automatic logic [WORD_W-1:0] ev_pack(
    input logic [CNT_FIELD_W-1:0] rx_cnt,
    input logic [CNT_FIELD_W-1:0] tx_cnt,
    input logic                   ne,
    input logic                   nf
  );
    logic [WORD_W-1:0] w;
    w            = '0;
    w[29:24]     = rx_cnt;
    w[21:16]     = tx_cnt;
    w[BIT_RX_NE] = ne;
    w[BIT_TX_NF] = nf;
    return w;
  endfunction

  // bytes a word read may remove: at most one word's worth
  function automatic logic [2:0] lane_take(input logic [CNT_FIELD_W-1:0] avail);
    return (avail >= CNT_FIELD_W'(LANES)) ? 3'd4 : avail[2:0];
  endfunction

  // swap between lane order (lane 0 = oldest) and bus order (oldest in MSB)
  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter  int DEPTH      = 32,
  parameter  int PUSH_LANES = 1,
  parameter  int POP_LANES  = 1,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int PUN_W      = $clog2(PUSH_LANES + 1),
  localparam int PON_W      = $clog2(POP_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PUN_W-1:0]        push_n,
  input  logic [PUSH_LANES*8-1:0] push_data,
  input  logic [PON_W-1:0]        pop_n,
  output logic [POP_LANES*8-1:0]  peek,
  output logic [CNT_W-1:0]        count
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++) begin
      if (PUN_W'(i) < push_n) mem[wr_ptr + PTR_W'(i)] <= push_data[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  // oldest bytes first; lanes beyond the fill level read zero
  always_comb begin
    peek = '0;
    for (int i = 0; i < POP_LANES; i++) begin
      if (CNT_W'(i) < count) peek[i*8 +: 8] = mem[rd_ptr + PTR_W'(i)];
    end
  end

  p_fifo_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(push_n) <= DEPTH));

  p_fifo_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pop_n) <= int'(count)));

endmodule

// File: rtl/spi_event_unit.sv
module spi_event_unit
  import spi_regfront_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic              ne_cond,
  input  logic              nf_cond,
  input  logic              clr_we,
  input  logic [1:0]        clr_bits,   // {rx not empty, tx not full}
  input  logic              mask_we,
  input  logic [WORD_W-1:0] mask_wdata,
  output logic [WORD_W-1:0] ev_word,
  output logic [WORD_W-1:0] mask_word,
  output logic              irq
);

  logic ne_q, nf_q;
  logic clr_ne, clr_nf;

  assign clr_ne = clr_we && clr_bits[1];
  assign clr_nf = clr_we && clr_bits[0];

  // write-one-to-clear has priority; a held condition re-arms next clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ne_q      <= 1'b0;
      nf_q      <= 1'b0;
      mask_word <= '0;
    end else begin
      ne_q <= clr_ne ? 1'b0 : (ne_q | ne_cond);
      nf_q <= clr_nf ? 1'b0 : (nf_q | nf_cond);
      if (mask_we) mask_word <= mask_wdata;
    end
  end

  assign ev_word = ev_pack(CNT_FIELD_W'(rx_cnt), CNT_FIELD_W'(tx_cnt), ne_q, nf_q);
  assign irq     = (ne_q && mask_word[BIT_RX_NE]) || (nf_q && mask_word[BIT_TX_NF]);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ne |=> !ne_q);

  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cond && !clr_nf) |=> nf_q);

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_word[BIT_RX_NE:BIT_TX_NF] == 2'b00) |-> !irq);

endmodule

// File: rtl/spi_cmd_unit.sv
module spi_cmd_unit
  import spi_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              eng_done,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_start,
  output logic              busy
);

  logic accept;
  assign accept = cmd_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      cmd_start <= 1'b0;
      busy      <= 1'b0;
    end else begin
      cmd_start <= accept;
      if (accept) begin
        cmd_word <= cmd_wdata;
        busy     <= 1'b1;
      end else if (eng_done) begin
        busy <= 1'b0;
      end
    end
  end

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable(cmd_word));

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter  int ADDR_W  = 8,
  parameter  int DEPTH   = 32,
  parameter  int NUM_SEL = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic                    bus_byte,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq,
  output logic [31:0]             mode_word,
  output logic [NUM_SEL*32-1:0]   sel_mode_flat,
  output logic [31:0]             cmd_word,
  output logic                    cmd_start,
  output logic                    xfer_busy,
  input  logic                    eng_done,
  output logic                    eng_tx_valid,
  input  logic                    eng_tx_ready,
  output logic [7:0]              eng_tx_data,
  input  logic                    eng_rx_valid,
  output logic                    eng_rx_ready,
  input  logic [7:0]              eng_rx_data
);

  logic wr, rd;
  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // ---------------- mode word ----------------
  always_ff @(posedge clk) begin
    if (!rst_n)                         mode_word <= '0;
    else if (wr && at(bus_addr, OFS_MODE)) mode_word <= bus_wdata;
  end

  // ---------------- per-select mode words ----------------
  logic [31:0] sel_q [NUM_SEL];
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)                                  sel_q[s] <= '0;
      else if (wr && at(bus_addr, OFS_SEL + 4*s))  sel_q[s] <= bus_wdata;
    end
    assign sel_mode_flat[s*32 +: 32] = sel_q[s];
  end

  // ---------------- transmit FIFO ----------------
  logic [CNT_W-1:0] tx_cnt, tx_free;
  logic [2:0]       tx_push_n;
  logic [31:0]      tx_push_data;
  logic [7:0]       tx_peek;
  logic             tx_pop;
  logic             tx_wr;

  assign tx_wr   = wr && at(bus_addr, OFS_TXD);
  assign tx_free = CNT_W'(DEPTH) - tx_cnt;

  always_comb begin
    tx_push_n    = 3'd0;
    tx_push_data = '0;
    if (tx_wr) begin
      if (bus_byte) begin
        tx_push_data = {24'b0, bus_wdata[7:0]};
        if (tx_free != '0) tx_push_n = 3'd1;
      end else begin
        tx_push_data = lane_swap(bus_wdata);
        if (tx_free >= CNT_W'(LANES)) tx_push_n = 3'd4;
      end
    end
  end

  assign eng_tx_valid = tx_cnt != '0;
  assign eng_tx_data  = tx_peek;
  assign tx_pop       = eng_tx_valid && eng_tx_ready;

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (tx_push_n),
    .push_data (tx_push_data),
    .pop_n     (tx_pop),
    .peek      (tx_peek),
    .count     (tx_cnt)
  );

  // ---------------- receive FIFO ----------------
  logic [CNT_W-1:0] rx_cnt;
  logic [2:0]       rx_pop_n;
  logic [31:0]      rx_peek;
  logic [31:0]      rx_rd_val;
  logic             rx_push;
  logic             rx_rd;

  assign eng_rx_ready = rx_cnt < CNT_W'(DEPTH);
  assign rx_push      = eng_rx_valid && eng_rx_ready;
  assign rx_rd        = rd && at(bus_addr, OFS_RXD);

  always_comb begin
    rx_pop_n  = 3'd0;
    rx_rd_val = '0;
    if (bus_byte) begin
      rx_rd_val = {24'b0, rx_peek[7:0]};
      if (rx_rd && rx_cnt != '0) rx_pop_n = 3'd1;
    end else begin
      rx_rd_val = lane_swap(rx_peek);
      if (rx_rd) rx_pop_n = lane_take(CNT_FIELD_W'(rx_cnt));
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (rx_push),
    .push_data (eng_rx_data),
    .pop_n     (rx_pop_n),
    .peek      (rx_peek),
    .count     (rx_cnt)
  );

  // ---------------- event and mask ----------------
  logic [31:0] ev_word, mask_word;

  spi_event_unit #(.CNT_W(CNT_W)) u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_cnt     (rx_cnt),
    .tx_cnt     (tx_cnt),
    .ne_cond    (rx_cnt != '0),
    .nf_cond    (tx_cnt < CNT_W'(DEPTH)),
    .clr_we     (wr && at(bus_addr, OFS_EVENT)),
    .clr_bits   ({bus_wdata[BIT_RX_NE], bus_wdata[BIT_TX_NF]}),
    .mask_we    (wr && at(bus_addr, OFS_MASK)),
    .mask_wdata (bus_wdata),
    .ev_word    (ev_word),
    .mask_word  (mask_word),
    .irq        (irq)
  );

  // ---------------- command ----------------
  spi_cmd_unit u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (wr && at(bus_addr, OFS_CMD)),
    .cmd_wdata (bus_wdata),
    .eng_done  (eng_done),
    .cmd_word  (cmd_word),
    .cmd_start (cmd_start),
    .busy      (xfer_busy)
  );

  // ---------------- read mux ----------------
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if      (at(bus_addr, OFS_MODE))  rd_val = mode_word;
    else if (at(bus_addr, OFS_EVENT)) rd_val = ev_word;
    else if (at(bus_addr, OFS_MASK))  rd_val = mask_word;
    else if (at(bus_addr, OFS_CMD))   rd_val = cmd_word;
    else if (at(bus_addr, OFS_RXD))   rd_val = rx_rd_val;
    else begin
      for (int s = 0; s < NUM_SEL; s++) begin
        if (at(bus_addr, OFS_SEL + 4*s)) rd_val = sel_q[s];
      end
    end
  end
  assign bus_rdata = rd ? rd_val : '0;

  p_rx_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CNT_W'(DEPTH) && !rx_rd) |=> rx_cnt == CNT_W'(DEPTH));

endmodule

// File: tb/spi_regfront_bench.sv
`timescale 1ns/1ps
module spi_regfront_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_en = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic [31:0]  mode_word;
  logic [127:0] sel_mode_flat;
  logic [31:0]  cmd_word;
  logic         cmd_start, xfer_busy;
  logic         eng_done = 1'b0;
  logic         eng_tx_valid;
  logic         eng_tx_ready = 1'b0;
  logic [7:0]   eng_tx_data;
  logic         eng_rx_valid = 1'b0;
  logic         eng_rx_ready;
  logic [7:0]   eng_rx_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_regfront u_spi_regfront (
    .clk, .rst_n, .bus_en, .bus_we, .bus_byte, .bus_addr, .bus_wdata, .bus_rdata,
    .irq, .mode_word, .sel_mode_flat, .cmd_word, .cmd_start, .xfer_busy, .eng_done,
    .eng_tx_valid, .eng_tx_ready, .eng_tx_data, .eng_rx_valid, .eng_rx_ready, .eng_rx_data
  );

  // {address, write data, expected read}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hA5A50F03, 32'hA5A50F03},
    {8'h08, 32'h00000300, 32'h00000300},
    {8'h20, 32'h11110001, 32'h11110001},
    {8'h24, 32'h22220002, 32'h22220002},
    {8'h28, 32'h33330003, 32'h33330003},
    {8'h2C, 32'h44440004, 32'h44440004},
    {8'h18, 32'hDEADBEEF, 32'h00000000},
    {8'h1C, 32'hCAFEF00D, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic b);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = b;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, input logic b, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_byte = b;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(posedge clk); @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);

    // R1: state while reset is held
    brd(8'h00, 1'b0, v); chk("R1 mode in reset", v, 0);
    brd(8'h04, 1'b0, v); chk("R1 event in reset", v, 0);
    brd(8'h0C, 1'b0, v); chk("R1 cmd in reset", v, 0);
    chk("R1 outputs in reset", {irq, cmd_start, xfer_busy, eng_tx_valid, eng_rx_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    brd(8'h04, 1'b0, v); chk("R1 event after reset", v, 32'h00000100);
    brd(8'h08, 1'b0, v); chk("R1 mask after reset", v, 0);

    // R7: clear wins in its own clock, condition re-arms one clock later
    bwr(8'h04, 32'hFFFFFFFF, 1'b0);
    brd(8'h04, 1'b0, v); chk("R7 cleared", v, 0);
    brd(8'h04, 1'b0, v); chk("R7 re-armed", v, 32'h00000100);

    // R2/R3: register table
    for (int i = 0; i < 8; i++) bwr(VEC[i][71:64], VEC[i][63:32], 1'b0);
    for (int i = 0; i < 8; i++) begin
      brd(VEC[i][71:64], 1'b0, v);
      chk(VEC[i][71:64] inside {8'h18, 8'h1C} ? "R3 reserved" : "R2 readback", v, VEC[i][31:0]);
    end
    chk("R2 mode_word", mode_word, 32'hA5A50F03);
    chk("R2 select 0", sel_mode_flat[31:0], 32'h11110001);
    chk("R2 select 3", sel_mode_flat[127:96], 32'h44440004);
    chk("R8 irq with nf masked", irq, 1);
    bwr(8'h08, 32'h0, 1'b0);
    chk("R8 irq unmasked", irq, 0);

    // R4/R6/R10: transmit path
    bwr(8'h10, 32'h11223344, 1'b0);
    bwr(8'h10, 32'h000000AB, 1'b1);
    brd(8'h04, 1'b0, v); chk("R6 tx count", v, 32'h00050100);
    chk("R10 tx valid", eng_tx_valid, 1);
    eng_tx_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1 chk("R4 tx order", eng_tx_data, (i == 4) ? 32'hAB : 32'(8'h11 * (i + 1)));
      @(posedge clk); @(negedge clk);
    end
    eng_tx_ready = 1'b0;
    chk("R10 tx empty", eng_tx_valid, 0);

    // R4/R7: fill, overflow drop, sticky nf stays clear while full
    for (int i = 0; i < 8; i++)
      bwr(8'h10, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)}, 1'b0);
    bwr(8'h10, 32'hEEEEEEEE, 1'b0);
    bwr(8'h04, 32'h00000100, 1'b0);
    brd(8'h04, 1'b0, v);
    brd(8'h04, 1'b0, v); chk("R7 nf stays clear while full / R6 count 32", v, 32'h00200000);
    eng_tx_ready = 1'b1;
    for (int i = 0; i < 32; i++) begin
      #1 if (eng_tx_data !== 8'(i)) chk("R4 tx fill order", eng_tx_data, i);
      @(posedge clk); @(negedge clk);
    end
    checks++;
    eng_tx_ready = 1'b0;
    chk("R4 dropped word absent", eng_tx_valid, 0);

    // R5/R6/R7/R8: receive path
    for (int i = 1; i <= 6; i++) rx_push(8'(16 * i));
    brd(8'h04, 1'b0, v); chk("R6 rx count", v, 32'h06000300);
    bwr(8'h08, 32'h00000200, 1'b0);
    chk("R8 irq on ne", irq, 1);
    brd(8'h14, 1'b0, v); chk("R5 word pop", v, 32'h10203040);
    brd(8'h04, 1'b0, v); chk("R6 rx count after pop", v, 32'h02000300);
    brd(8'h14, 1'b1, v); chk("R5 byte pop 1", v, 32'h50);
    brd(8'h14, 1'b1, v); chk("R5 byte pop 2", v, 32'h60);
    brd(8'h14, 1'b1, v); chk("R5 empty byte", v, 0);
    brd(8'h14, 1'b0, v); chk("R5 empty word", v, 0);
    brd(8'h04, 1'b0, v); chk("R7 ne sticky", v, 32'h00000300);
    chk("R8 irq sticky", irq, 1);
    bwr(8'h04, 32'h00000200, 1'b0);
    brd(8'h04, 1'b0, v);
    brd(8'h04, 1'b0, v); chk("R7 ne cleared", v, 32'h00000100);
    chk("R8 irq after clear", irq, 0);
    rx_push(8'h77); rx_push(8'h88);
    brd(8'h14, 1'b0, v); chk("R5 partial word", v, 32'h77880000);
    bwr(8'h08, 32'h0, 1'b0);

    // R10: receive full
    for (int i = 0; i < 32; i++) rx_push(8'(i));
    chk("R10 rx ready low", eng_rx_ready, 0);
    rx_push(8'hFF);
    brd(8'h04, 1'b0, v); chk("R10 full count", v, 32'h20000300);
    for (int i = 0; i < 8; i++) begin
      brd(8'h14, 1'b0, v);
      chk("R10 full drain", v, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
    end
    chk("R10 rx ready again", eng_rx_ready, 1);

    // R9: command
    bwr(8'h0C, 32'h40000007, 1'b0);
    chk("R9 start", {cmd_start, xfer_busy}, 32'h3);
    chk("R9 word", cmd_word, 32'h40000007);
    @(negedge clk);
    chk("R9 one clock", cmd_start, 0);
    bwr(8'h0C, 32'h00000001, 1'b0);
    chk("R9 busy write no start", cmd_start, 0);
    brd(8'h0C, 1'b0, v); chk("R9 busy write ignored", v, 32'h40000007);
    eng_done = 1'b1; @(posedge clk); @(negedge clk); eng_done = 1'b0;
    chk("R9 done clears busy", xfer_busy, 0);
    bwr(8'h0C, 32'h00000002, 1'b0);
    chk("R9 second command", {cmd_start, xfer_busy, cmd_word[29:0]}, 32'hC0000002);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule